// File: doc/BRIEF.md
# Program Counter Sequencer with Exception Vectoring

This block holds the instruction-fetch address of a single-cycle 32-bit processor and chooses, on every rising clock edge, the address of the next instruction. The decoder supplies a small select code that names the kind of control transfer in the current instruction. The ALU supplies the zero flag from the comparison it has just done. The block then loads one of six values into the program counter: the sequential address, a PC-relative branch target, an absolute jump target, a target read from a register, a fixed handler address, or the boot address.

The branch target comes from an adder that belongs to this block and is separate from the ALU, because the ALU is busy with the comparison during a branch. The absolute jump target is built by concatenation rather than arithmetic. Reset, an illegal opcode and an interrupt override the decoder, and each of them sends the PC to its own fixed address. All three addresses are parameters.

Top module: `fetch_pc_sequencer`

## Requirements
- R1: When `rst` is high at a rising edge, `pc` becomes `RESET_VEC` (default 0x00000000). This happens whatever the values of every other input.
- R2: `pcPlus4` always equals `pc` + 4, modulo 2^32. With no override active, select codes 0, 5, 6 and 7 load `pc` + 4.
- R3: Select code 1 (branch if equal) loads `pcPlus4` + (sign-extended `brOffset` << 2) when `aluZero` is 1. When `aluZero` is 0 it loads `pc` + 4.
- R4: Select code 2 (branch if not equal) loads the branch target of R3 when `aluZero` is 0. When `aluZero` is 1 it loads `pc` + 4.
- R5: Select code 3 (absolute jump) loads {`pcPlus4`[31:28], `jumpField`, 2'b00}. The top four bits come from the incremented PC, not from the current PC.
- R6: Select code 4 (register jump) loads `regTarget` with its two low bits forced to zero.
- R7: With `rst` low and `illegalOp` low, a high `irq` loads `IRQ_VEC` (default 0x00000040). It overrides every select code.
- R8: With `rst` low, a high `illegalOp` loads `ILL_VEC` (default 0x00000080). It overrides `irq` and every select code.
- R9: After reset, bits 1:0 of `pc` are always zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC loads on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pcSel | input | 3 | Transfer kind from the decoder: 0 sequential, 1 branch-equal, 2 branch-not-equal, 3 absolute jump, 4 register jump, 5 to 7 sequential |
| aluZero | input | 1 | Zero flag of the ALU comparison |
| irq | input | 1 | Interrupt request, sampled at the edge |
| illegalOp | input | 1 | The decoder found an unknown opcode |
| brOffset | input | 16 | Signed branch offset, counted in words |
| jumpField | input | 26 | Word-address field of an absolute jump |
| regTarget | input | 32 | Register value used as the jump target |
| pc | output | 32 | Current fetch address |
| pcPlus4 | output | 32 | Current fetch address plus four |

## Verification
The assertions take for granted that `rst` is high from time zero until at least the first clock edge. This means the PC never holds an unknown value while the assertions are enabled. They also take for granted that `pcSel`, `aluZero`, `irq` and `illegalOp` are always 0 or 1 and are stable around the clock edge.

The bench holds `rst` high from the start. It changes every input only on the falling edge. In the reset cycles it drives conflicting override and select values on purpose, so that the priority of reset is exercised under the same conditions the assertions assume.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;

  typedef enum logic [2:0] {
    SEL_SEQ  = 3'd0,
    SEL_BEQ  = 3'd1,
    SEL_BNE  = 3'd2,
    SEL_JABS = 3'd3,
    SEL_JREG = 3'd4
  } pcSelE;

  typedef struct packed {
    logic ldReset;
    logic ldIll;
    logic ldIrq;
    logic ldBranch;
    logic ldJump;
    logic ldReg;
  } pcStrobeT;

endpackage

// File: rtl/pc_seq_ctrl.sv
module pc_seq_ctrl
  import pc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] pcSel,
  input  logic       aluZero,
  input  logic       irq,
  input  logic       illegalOp,
  output pcStrobeT   strb
);

  always_comb begin
    strb = '0;
    if (rst) begin
      strb.ldReset = 1'b1;
    end else if (illegalOp) begin
      strb.ldIll = 1'b1;
    end else if (irq) begin
      strb.ldIrq = 1'b1;
    end else begin
      case (pcSelE'(pcSel))
        SEL_BEQ:  strb.ldBranch = aluZero;
        SEL_BNE:  strb.ldBranch = !aluZero;
        SEL_JABS: strb.ldJump   = 1'b1;
        SEL_JREG: strb.ldReg    = 1'b1;
        default:  strb          = '0;
      endcase
    end
  end

  AST_RESET_WINS: assert property (@(posedge clk)
    rst |-> (strb.ldReset && !strb.ldIll && !strb.ldIrq && !strb.ldBranch && !strb.ldJump && !strb.ldReg)); // R1

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb)); // R8

  AST_BEQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    (pcSel == 3'd1 && !irq && !illegalOp) |-> (strb.ldBranch == aluZero)); // R3

  AST_BNE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (pcSel == 3'd2 && !irq && !illegalOp) |-> (strb.ldBranch != aluZero)); // R4

  AST_IRQ_OVER_DECODE: assert property (@(posedge clk) disable iff (rst)
    (irq && !illegalOp) |-> !(strb.ldBranch || strb.ldJump || strb.ldReg)); // R7

  AST_ILL_OVER_IRQ: assert property (@(posedge clk) disable iff (rst)
    illegalOp |-> (strb.ldIll && !strb.ldIrq)); // R8

endmodule

// File: rtl/pc_seq_dp.sv
module pc_seq_dp
  import pc_seq_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          OFF_W     = 16,
  parameter int          JF_W      = 26,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000,
  parameter logic [31:0] IRQ_VEC   = 32'h0000_0040,
  parameter logic [31:0] ILL_VEC   = 32'h0000_0080
) (
  input  logic             clk,
  input  logic             rst,
  input  pcStrobeT         strb,
  input  logic [OFF_W-1:0] brOffset,
  input  logic [JF_W-1:0]  jumpField,
  input  logic [XLEN-1:0]  regTarget,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  pcPlus4
);

  localparam int HI_W  = XLEN - JF_W - 2;
  localparam int EXT_W = XLEN - OFF_W - 2;

  logic [XLEN-1:0] pcReg;
  logic [XLEN-1:0] brTarget;
  logic [XLEN-1:0] jTarget;
  logic [XLEN-1:0] rTarget;
  logic [XLEN-1:0] pcNext;

  assign pcPlus4  = pcReg + XLEN'(4);
  assign brTarget = pcPlus4 + {{EXT_W{brOffset[OFF_W-1]}}, brOffset, 2'b00};
  assign jTarget  = {pcPlus4[XLEN-1 -: HI_W], jumpField, 2'b00};
  assign rTarget  = {regTarget[XLEN-1:2], 2'b00};

  always_comb begin
    if (strb.ldReset)       pcNext = XLEN'(RESET_VEC);
    else if (strb.ldIll)    pcNext = XLEN'(ILL_VEC);
    else if (strb.ldIrq)    pcNext = XLEN'(IRQ_VEC);
    else if (strb.ldBranch) pcNext = brTarget;
    else if (strb.ldJump)   pcNext = jTarget;
    else if (strb.ldReg)    pcNext = rTarget;
    else                    pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    pcReg <= pcNext;
  end

  assign pc = pcReg;

  AST_BOOT_ADDR: assert property (@(posedge clk)
    rst |=> (pc == XLEN'(RESET_VEC))); // R1

  AST_STEP_FOUR: assert property (@(posedge clk) disable iff (rst)
    (strb == '0) |=> (pc == $past(pc) + XLEN'(4))); // R2

  AST_IRQ_ADDR: assert property (@(posedge clk) disable iff (rst)
    strb.ldIrq |=> (pc == XLEN'(IRQ_VEC))); // R7

  AST_ILL_ADDR: assert property (@(posedge clk) disable iff (rst)
    strb.ldIll |=> (pc == XLEN'(ILL_VEC))); // R8

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (pc[1:0] == 2'b00)); // R9

endmodule

// File: rtl/fetch_pc_sequencer.sv
module fetch_pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          OFF_W     = 16,
  parameter int          JF_W      = 26,
  parameter logic [31:0] RESET_VEC = 32'h0000_0000,
  parameter logic [31:0] IRQ_VEC   = 32'h0000_0040,
  parameter logic [31:0] ILL_VEC   = 32'h0000_0080
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       pcSel,
  input  logic             aluZero,
  input  logic             irq,
  input  logic             illegalOp,
  input  logic [OFF_W-1:0] brOffset,
  input  logic [JF_W-1:0]  jumpField,
  input  logic [XLEN-1:0]  regTarget,
  output logic [XLEN-1:0]  pc,
  output logic [XLEN-1:0]  pcPlus4
);

  pcStrobeT strb;

  pc_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .pcSel     (pcSel),
    .aluZero   (aluZero),
    .irq       (irq),
    .illegalOp (illegalOp),
    .strb      (strb)
  );

  pc_seq_dp #(
    .XLEN      (XLEN),
    .OFF_W     (OFF_W),
    .JF_W      (JF_W),
    .RESET_VEC (RESET_VEC),
    .IRQ_VEC   (IRQ_VEC),
    .ILL_VEC   (ILL_VEC)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .brOffset  (brOffset),
    .jumpField (jumpField),
    .regTarget (regTarget),
    .pc        (pc),
    .pcPlus4   (pcPlus4)
  );

endmodule

// File: tb/fetch_pc_sequencer_test.sv
module fetch_pc_sequencer_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  pcSel = 3'd0;
  logic        aluZero = 1'b0;
  logic        irq = 1'b0;
  logic        illegalOp = 1'b0;
  logic [15:0] brOffset = '0;
  logic [25:0] jumpField = '0;
  logic [31:0] regTarget = '0;
  logic [31:0] pc;
  logic [31:0] pcPlus4;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } itemT;

  itemT        sbQ[$];
  logic [31:0] modelPc = '0;
  int          nTests = 0;
  int          nFail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_pc_sequencer uut (
    .clk       (clk),
    .rst       (rst),
    .pcSel     (pcSel),
    .aluZero   (aluZero),
    .irq       (irq),
    .illegalOp (illegalOp),
    .brOffset  (brOffset),
    .jumpField (jumpField),
    .regTarget (regTarget),
    .pc        (pc),
    .pcPlus4   (pcPlus4)
  );

  function automatic logic [31:0] refNext(
    input logic r, input logic [2:0] s, input logic z, input logic ir, input logic il,
    input logic [15:0] off, input logic [25:0] jf, input logic [31:0] rt, input logic [31:0] cur);
    logic [31:0] inc;
    logic [31:0] br;
    inc = cur + 32'd4;
    br  = inc + (32'(signed'(off)) <<< 2);
    if (r) return 32'h0000_0000;
    if (il) return 32'h0000_0080;
    if (ir) return 32'h0000_0040;
    if (s == 3'd1) return z ? br : inc;
    if (s == 3'd2) return z ? inc : br;
    if (s == 3'd3) return {inc[31:28], jf, 2'b00};
    if (s == 3'd4) return {rt[31:2], 2'b00};
    return inc;
  endfunction

  task automatic step(
    input logic r, input logic [2:0] s, input logic z, input logic ir, input logic il,
    input logic [15:0] off, input logic [25:0] jf, input logic [31:0] rt, input string tag);
    itemT it;
    @(negedge clk);
    rst = r; pcSel = s; aluZero = z; irq = ir; illegalOp = il;
    brOffset = off; jumpField = jf; regTarget = rt;
    it.exp = refNext(r, s, z, ir, il, off, jf, rt, modelPc);
    it.tag = tag;
    modelPc = it.exp;
    sbQ.push_back(it);
  endtask

  initial begin : monitor
    itemT it;
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        it = sbQ.pop_front();
        nTests++;
        if (pc !== it.exp) begin
          nFail++;
          $display("FAIL %s: pc=%h expected %h", it.tag, pc, it.exp);
        end
        nTests++;
        if (pcPlus4 !== it.exp + 32'd4) begin
          nFail++;
          $display("FAIL R2: pcPlus4=%h expected %h", pcPlus4, it.exp + 32'd4);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin : driver
    // R1: reset beats conflicting override and select inputs
    step(1, 3'd3, 1, 1, 1, 16'h1234, 26'h3ff_ffff, 32'hdead_beef, "R1");
    step(1, 3'd4, 0, 1, 0, 16'h0000, 26'h0, 32'h1111_1110, "R1");
    // R2: sequential, including the unused codes
    step(0, 3'd0, 0, 0, 0, 16'h0, 26'h0, 32'h0, "R2");
    step(0, 3'd5, 1, 0, 0, 16'h7fff, 26'h0, 32'h0, "R2");
    step(0, 3'd6, 0, 0, 0, 16'h0, 26'h0, 32'h0, "R2");
    step(0, 3'd7, 1, 0, 0, 16'h0, 26'h0, 32'h0, "R2");
    // R3: branch if equal, taken forward and backward, and not taken
    step(0, 3'd1, 1, 0, 0, 16'h0010, 26'h0, 32'h0, "R3");
    step(0, 3'd1, 1, 0, 0, 16'hfff0, 26'h0, 32'h0, "R3");
    step(0, 3'd1, 0, 0, 0, 16'h0100, 26'h0, 32'h0, "R3");
    // R4: branch if not equal
    step(0, 3'd2, 0, 0, 0, 16'h0040, 26'h0, 32'h0, "R4");
    step(0, 3'd2, 1, 0, 0, 16'h0040, 26'h0, 32'h0, "R4");
    step(0, 3'd2, 0, 0, 0, 16'h8000, 26'h0, 32'h0, "R4");
    // R6 and R9: register jump with misaligned low bits
    step(0, 3'd4, 0, 0, 0, 16'h0, 26'h0, 32'ha000_1003, "R6");
    // R5: jump keeps the top nibble of the incremented PC
    step(0, 3'd3, 0, 0, 0, 16'h0, 26'h2ab_cdef, 32'h0, "R5");
    step(0, 3'd4, 0, 0, 0, 16'h0, 26'h0, 32'hffff_fffe, "R9");
    step(0, 3'd3, 0, 0, 0, 16'h0, 26'h012_3456, 32'h0, "R5");
    // R7: interrupt over jump
    step(0, 3'd3, 0, 1, 0, 16'h0, 26'h3ff_ffff, 32'h0, "R7");
    step(0, 3'd1, 1, 1, 0, 16'h0100, 26'h0, 32'h0, "R7");
    // R8: illegal opcode over interrupt and register jump
    step(0, 3'd4, 0, 1, 1, 16'h0, 26'h0, 32'h5555_5554, "R8");
    step(0, 3'd0, 0, 0, 1, 16'h0, 26'h0, 32'h0, "R8");
    step(0, 3'd0, 0, 0, 0, 16'h0, 26'h0, 32'h0, "R2");
    // R1: reset in mid-run with everything else asserted
    step(1, 3'd2, 0, 1, 1, 16'hffff, 26'h3ff_ffff, 32'hffff_ffff, "R1");
    step(0, 3'd0, 0, 0, 0, 16'h0, 26'h0, 32'h0, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule